// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Register File

This block holds the configuration state of one plug-and-play expansion card. A host reaches it through a plain address/data port. A write is accepted on the clock edge that sees `wr_en_i`. A read strobe on `rd_en_i` returns its byte on `rdata_o` after the next edge. The block tracks whether the card is waiting for the initiation key or is open for configuration. The key detection logic outside the block reports a match on `key_seen_i`. The block also holds the card select number and a command register whose bits act only in the cycle they are written.

Resource data is read one byte at a time through a data port that is paced by a ready flag in a status byte. The block also holds the settings of one logical device: the activate bit, the I/O range-check control, the memory width control, and the interrupt number and type. These settings drive the device's response on its I/O read path.

Top module: `pnp_cfg_regs`

Register addresses: command 0x02 (write only), resource restart 0x03, resource data 0x04, status 0x05 (bit 0 = ready), card select number 0x06, activate 0x30 (bit 0), range check 0x31 (bit 1 enable, bit 0 pattern select), memory control 0x42 (bit 1 width, bit 0 limit kind), interrupt number 0x70 (bits 3:0), interrupt type 0x71 (bit 1 polarity, bit 0 trigger).

## Requirements
- R1: After reset the card is waiting for the key (`cfg_state_o`=0) and the card select number is 0x00. Activate and range check read 0x00, memory control reads 0x01, interrupt number reads 0x00, interrupt type reads 0x02, and status reads 0x01.
- R2: While waiting for the key, writes change nothing and reads return 0x00. A `key_seen_i` pulse moves the card to the configured state (`cfg_state_o`=1) at the next edge.
- R3: Writing the command register with bit 2 set clears the card select number to 0x00 and leaves the card configured.
- R4: Writing the command register with bit 1 set returns the card to waiting for the key at the next edge.
- R5: Writing the command register with bit 0 set restores activate, range check, memory width, interrupt number and interrupt type to their reset values. The card select number is kept. The command register holds nothing and always reads 0x00.
- R6: Each data read taken while ready returns resource byte i = (29*i + 0x1A) mod 256 and advances the index. Status bit 0 drops after the read and reads as 1 again two edges after it. Once all 16 bytes have been read, further reads return 0x00.
- R7: A data read while status bit 0 is clear returns 0x00 and does not advance the index.
- R8: A write to the restart address, or a command bit 0 write, sets the index back to byte 0. Status bit 0 is clear at the next read and set again by the second edge.
- R9: Activate bit 0 drives `dev_active_o`. While the device is active, `io_resp_o` is 1 and `io_rdata_o` passes `io_dev_data_i` through.
- R10: Range check bits 7:2 read 0. While the device is inactive and bit 1 is set, `io_resp_o` is 1 and `io_rdata_o` is 0x55 when bit 0 is set, 0xAA when it is clear. The range check has no effect while the device is active.
- R11: Memory control bit 1 is writable (1 = 16-bit, 0 = 8-bit). Bit 0 is read-only at its built-in value 1 (upper limit) and ignores writes.
- R12: Interrupt type bits 1:0 are writable and bits 7:2 read 0. The interrupt number keeps bits 3:0 of the written byte.
- R13: A read of any unimplemented address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_seen_i | input | 1 | One-cycle pulse when the initiation key has been recognized |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid after the edge that took the read |
| cfg_state_o | output | 1 | 1 when configured, 0 when waiting for the key |
| csn_o | output | 8 | Card select number |
| dev_active_o | output | 1 | Logical device active |
| io_dev_data_i | input | 8 | Data the device returns on an I/O read when active |
| io_resp_o | output | 1 | Device answers I/O reads |
| io_rdata_o | output | 8 | I/O read data: device data or range-check pattern |

## Verification
The hardest case to reach is the gap in the ready flag. Only a read that arrives in the cycle right after a data read can see the flag clear, and the same holds for the cycle right after a restart. The bench issues its reads back to back, with no idle cycle between them, so that the status byte and a refused data read both land in that one-cycle gap. It then reads again two edges later and expects the flag set and the index unchanged. The command-driven restore is reached by first moving every device register away from its reset value, so that each restore shows up at the read port.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic {
    ST_WAIT_KEY = 1'b0,
    ST_CONFIG   = 1'b1
  } card_st_e;

  localparam logic [7:0] A_CMD    = 8'h02;
  localparam logic [7:0] A_WAKE   = 8'h03;
  localparam logic [7:0] A_DATA   = 8'h04;
  localparam logic [7:0] A_STAT   = 8'h05;
  localparam logic [7:0] A_CSN    = 8'h06;
  localparam logic [7:0] A_ACT    = 8'h30;
  localparam logic [7:0] A_RCHK   = 8'h31;
  localparam logic [7:0] A_MEMCTL = 8'h42;
  localparam logic [7:0] A_IRQN   = 8'h70;
  localparam logic [7:0] A_IRQT   = 8'h71;

  // command bit positions
  localparam int CMD_LDEV_RST = 0;
  localparam int CMD_WAIT_KEY = 1;
  localparam int CMD_CSN_CLR  = 2;

  localparam logic [7:0] RCHK_PAT_SET = 8'h55;
  localparam logic [7:0] RCHK_PAT_CLR = 8'hAA;

  function automatic logic [7:0] res_byte(input int unsigned idx);
    return 8'(idx * 29 + 26);
  endfunction
endpackage

// File: rtl/pnp_cfg_field.sv
module pnp_cfg_field #(
  parameter int         W    = 1,
  parameter logic [7:0] ADDR = 8'h00,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [7:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  timeunit 1ns; timeprecision 1ps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     q_o <= RST;
    else if (clr_i)                  q_o <= RST;
    else if (wr_i && addr_i == ADDR) q_o <= wdata_i;
  end
endmodule

// File: rtl/pnp_card_ctl.sv
module pnp_card_ctl
  import pnp_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_seen_i,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       cfg_o,
  output logic       wr_ok_o,
  output logic [7:0] csn_o,
  output logic       ldev_rst_o,
  output logic       restart_o
);
  timeunit 1ns; timeprecision 1ps;

  card_st_e st_q;
  logic     cmd_wr;

  assign cfg_o      = (st_q == ST_CONFIG);
  assign wr_ok_o    = wr_en_i && cfg_o;
  assign cmd_wr     = wr_ok_o && (addr_i == A_CMD);
  assign ldev_rst_o = cmd_wr && wdata_i[CMD_LDEV_RST];
  assign restart_o  = ldev_rst_o || (wr_ok_o && addr_i == A_WAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               st_q <= ST_WAIT_KEY;
    else if (cmd_wr && wdata_i[CMD_WAIT_KEY])  st_q <= ST_WAIT_KEY;
    else if (st_q == ST_WAIT_KEY && key_seen_i) st_q <= ST_CONFIG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              csn_o <= 8'h00;
    else if (cmd_wr && wdata_i[CMD_CSN_CLR])  csn_o <= 8'h00;
    else if (wr_ok_o && addr_i == A_CSN)      csn_o <= wdata_i;
  end
endmodule

// File: rtl/pnp_res_reader.sv
module pnp_res_reader
  import pnp_cfg_pkg::*;
#(
  parameter int RES_BYTES = 16,
  parameter int READY_LAT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       restart_i,
  output logic [7:0] data_o,
  output logic       ready_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PTR_W = $clog2(RES_BYTES + 1);
  localparam int CNT_W = $clog2(READY_LAT + 1);
  localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(RES_BYTES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(READY_LAT - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;
  logic             take;

  assign take    = rd_i && ready_q;
  assign ready_o = ready_q;
  assign data_o  = (ready_q && ptr_q != PTR_END) ? res_byte(32'(ptr_q)) : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else if (restart_i) begin
      ptr_q   <= '0;
      cnt_q   <= CNT_LOAD;
      ready_q <= 1'b0;
    end else if (take) begin
      if (ptr_q != PTR_END) ptr_q <= ptr_q + 1'b1;
      cnt_q   <= CNT_LOAD;
      ready_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) ready_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pnp_ldev_regs.sv
module pnp_ldev_regs
  import pnp_cfg_pkg::*;
#(
  parameter int         IRQ_W        = 4,
  parameter logic       MEM16_RST    = 1'b0,
  parameter logic [1:0] IRQ_TYPE_RST = 2'b10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             clr_i,
  output logic             act_o,
  output logic [1:0]       rchk_o,
  output logic             mem16_o,
  output logic [IRQ_W-1:0] irqn_o,
  output logic [1:0]       irqt_o
);
  timeunit 1ns; timeprecision 1ps;

  pnp_cfg_field #(.W(1), .ADDR(A_ACT), .RST(1'b0)) u_act (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i(wdata_i[0]), .clr_i, .q_o(act_o));

  pnp_cfg_field #(.W(2), .ADDR(A_RCHK), .RST(2'b00)) u_rchk (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i(wdata_i[1:0]), .clr_i, .q_o(rchk_o));

  pnp_cfg_field #(.W(1), .ADDR(A_MEMCTL), .RST(MEM16_RST)) u_mem16 (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i(wdata_i[1]), .clr_i, .q_o(mem16_o));

  pnp_cfg_field #(.W(IRQ_W), .ADDR(A_IRQN), .RST('0)) u_irqn (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i(wdata_i[IRQ_W-1:0]), .clr_i, .q_o(irqn_o));

  pnp_cfg_field #(.W(2), .ADDR(A_IRQT), .RST(IRQ_TYPE_RST)) u_irqt (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i(wdata_i[1:0]), .clr_i, .q_o(irqt_o));
endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_cfg_pkg::*;
#(
  parameter int         RES_BYTES    = 16,
  parameter int         READY_LAT    = 2,
  parameter int         IRQ_W        = 4,
  parameter logic       MEM16_RST    = 1'b0,
  parameter logic       MEM_UPPER    = 1'b1,
  parameter logic [1:0] IRQ_TYPE_RST = 2'b10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_seen_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       cfg_state_o,
  output logic [7:0] csn_o,
  output logic       dev_active_o,
  input  logic [7:0] io_dev_data_i,
  output logic       io_resp_o,
  output logic [7:0] io_rdata_o
);
  timeunit 1ns; timeprecision 1ps;

  logic             wr_ok, rd_ok, ldev_rst, restart;
  logic [7:0]       res_data;
  logic             res_ready;
  logic             act, mem16;
  logic [1:0]       rchk, irqt;
  logic [IRQ_W-1:0] irqn;
  logic [7:0]       rd_mux;

  pnp_card_ctl u_ctl (
    .clk_i, .rst_ni, .key_seen_i, .wr_en_i, .addr_i, .wdata_i,
    .cfg_o(cfg_state_o), .wr_ok_o(wr_ok), .csn_o,
    .ldev_rst_o(ldev_rst), .restart_o(restart));

  assign rd_ok = rd_en_i && cfg_state_o;

  pnp_res_reader #(.RES_BYTES(RES_BYTES), .READY_LAT(READY_LAT)) u_res (
    .clk_i, .rst_ni, .rd_i(rd_ok && addr_i == A_DATA), .restart_i(restart),
    .data_o(res_data), .ready_o(res_ready));

  pnp_ldev_regs #(.IRQ_W(IRQ_W), .MEM16_RST(MEM16_RST), .IRQ_TYPE_RST(IRQ_TYPE_RST)) u_ldev (
    .clk_i, .rst_ni, .wr_i(wr_ok), .addr_i, .wdata_i, .clr_i(ldev_rst),
    .act_o(act), .rchk_o(rchk), .mem16_o(mem16), .irqn_o(irqn), .irqt_o(irqt));

  always_comb begin
    case (addr_i)
      A_DATA:   rd_mux = res_data;
      A_STAT:   rd_mux = {7'b0, res_ready};
      A_CSN:    rd_mux = csn_o;
      A_ACT:    rd_mux = {7'b0, act};
      A_RCHK:   rd_mux = {6'b0, rchk};
      A_MEMCTL: rd_mux = {6'b0, mem16, MEM_UPPER};
      A_IRQN:   rd_mux = 8'(irqn);
      A_IRQT:   rd_mux = {6'b0, irqt};
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= 8'h00;
    else if (rd_en_i) rdata_o <= rd_ok ? rd_mux : 8'h00;
  end

  // range check applies only while the device is inactive
  assign dev_active_o = act;
  assign io_resp_o    = act || rchk[1];
  assign io_rdata_o   = act     ? io_dev_data_i :
                        rchk[1] ? (rchk[0] ? RCHK_PAT_SET : RCHK_PAT_CLR) : 8'h00;
endmodule

// File: rtl/pnp_cfg_regs_chk.sv
module pnp_cfg_regs_chk
  import pnp_cfg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       cfg_state_o,
  input logic [7:0] csn_o,
  input logic       dev_active_o,
  input logic       res_ready
);
  timeunit 1ns; timeprecision 1ps;

  logic cmd_wr;
  assign cmd_wr = wr_en_i && cfg_state_o && addr_i == A_CMD;

  // R2
  wait_key_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_state_o && wr_en_i) |=> $stable(csn_o));
  // R2
  wait_key_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_state_o && rd_en_i) |=> rdata_o == 8'h00);
  // R3
  csn_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[CMD_CSN_CLR]) |=> csn_o == 8'h00);
  // R4
  back_to_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[CMD_WAIT_KEY]) |=> !cfg_state_o);
  // R5
  ldev_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[CMD_LDEV_RST]) |=> !dev_active_o);
  // R6
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && cfg_state_o && addr_i == A_DATA && res_ready) |=> !res_ready);
  // R7
  not_ready_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && cfg_state_o && addr_i == A_DATA && !res_ready) |=> rdata_o == 8'h00);
  // R13
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[7:4] == 4'h1) |=> rdata_o == 8'h00);
endmodule

bind pnp_cfg_regs pnp_cfg_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .cfg_state_o(cfg_state_o), .csn_o(csn_o), .dev_active_o(dev_active_o),
  .res_ready(res_ready));

// File: tb/test_pnp_cfg_regs.sv
module test_pnp_cfg_regs;
  timeunit 1ns; timeprecision 1ps;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       key_seen_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       cfg_state_o;
  logic [7:0] csn_o;
  logic       dev_active_o;
  logic [7:0] io_dev_data_i = 8'h3C;
  logic       io_resp_o;
  logic [7:0] io_rdata_o;

  pnp_cfg_regs i_pnp_cfg_regs (.*);

  always #2.5 clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  function automatic logic [7:0] rbyte(input int i);
    return 8'((29 * i + 26) % 256);
  endfunction

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // driver: called and returning on a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    addr_i = a; rd_en_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
  endtask

  // monitor
  always @(posedge clk_i) rd_seen <= rd_en_i;
  always @(negedge clk_i) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard: unexpected read data %02h expected none", rdata_o);
      end else begin
        chk(rdata_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    // R1 reset state
    chk({7'b0, cfg_state_o}, 8'h00, "R1 state");
    chk(csn_o, 8'h00, "R1 csn");
    chk({7'b0, dev_active_o}, 8'h00, "R1 active");
    chk({7'b0, io_resp_o}, 8'h00, "R1 io_resp");
    // R2 wait-for-key ignores access
    wr(8'h06, 8'h77);
    chk(csn_o, 8'h00, "R2 csn write ignored");
    rd(8'h05, 8'h00, "R2 read in wait-key");
    key_seen_i = 1'b1; idle(); key_seen_i = 1'b0;
    chk({7'b0, cfg_state_o}, 8'h01, "R2 configured");
    // R1 reset values
    rd(8'h05, 8'h01, "R1 status");
    rd(8'h30, 8'h00, "R1 act");
    rd(8'h31, 8'h00, "R1 rchk");
    rd(8'h42, 8'h01, "R1 memctl");
    rd(8'h70, 8'h00, "R1 irqn");
    rd(8'h71, 8'h02, "R1 irqt");
    // card select number
    wr(8'h06, 8'h05);
    rd(8'h06, 8'h05, "R3 csn set");
    // R9 activate
    wr(8'h30, 8'h01);
    rd(8'h30, 8'h01, "R9 act readback");
    chk({7'b0, dev_active_o}, 8'h01, "R9 dev_active_o");
    chk(io_rdata_o, 8'h3C, "R9 passthrough");
    chk({7'b0, io_resp_o}, 8'h01, "R9 io_resp");
    // R10 range check
    wr(8'h31, 8'hFF);
    rd(8'h31, 8'h03, "R10 upper bits zero");
    chk(io_rdata_o, 8'h3C, "R10 ignored while active");
    wr(8'h30, 8'h00);
    chk({7'b0, io_resp_o}, 8'h01, "R10 io_resp inactive");
    chk(io_rdata_o, 8'h55, "R10 pattern bit0=1");
    wr(8'h31, 8'h02);
    chk(io_rdata_o, 8'hAA, "R10 pattern bit0=0");
    wr(8'h31, 8'h00);
    chk({7'b0, io_resp_o}, 8'h00, "R10 check off");
    // R11 memory control
    wr(8'h42, 8'h02);
    rd(8'h42, 8'h03, "R11 width 16");
    wr(8'h42, 8'h00);
    rd(8'h42, 8'h01, "R11 bit0 read-only");
    wr(8'h42, 8'hFE);
    rd(8'h42, 8'h03, "R11 width 16 again");
    // R12 interrupt registers
    wr(8'h71, 8'hFF);
    rd(8'h71, 8'h03, "R12 irqt mask");
    wr(8'h71, 8'h01);
    rd(8'h71, 8'h01, "R12 irqt edge/level");
    wr(8'h70, 8'hFB);
    rd(8'h70, 8'h0B, "R12 irqn");
    // R13 reserved, R5 command reads 0
    rd(8'h10, 8'h00, "R13 addr 10");
    rd(8'h2A, 8'h00, "R13 addr 2A");
    rd(8'hFF, 8'h00, "R13 addr FF");
    rd(8'h02, 8'h00, "R5 command reads zero");
    // R6/R7 resource data, back-to-back reads
    rd(8'h04, rbyte(0), "R6 byte0");
    rd(8'h05, 8'h00, "R6 ready low");
    rd(8'h05, 8'h01, "R6 ready back");
    rd(8'h04, rbyte(1), "R6 byte1");
    rd(8'h04, 8'h00, "R7 not ready");
    rd(8'h05, 8'h01, "R7 ready");
    rd(8'h04, rbyte(2), "R7 index kept");
    // R8 restart
    idle();
    wr(8'h03, 8'h00);
    rd(8'h05, 8'h00, "R8 ready low after restart");
    rd(8'h05, 8'h01, "R8 ready after restart");
    for (int i = 0; i < 16; i++) begin
      rd(8'h04, rbyte(i), "R6 sweep");
      idle();
    end
    rd(8'h04, 8'h00, "R6 past end");
    idle();
    // R5 command bit0 restore
    wr(8'h30, 8'h01);
    wr(8'h31, 8'h03);
    wr(8'h03, 8'h00);
    idle(); idle();
    rd(8'h04, rbyte(0), "R8 byte0 before");
    idle();
    wr(8'h02, 8'h01);
    rd(8'h05, 8'h00, "R8 ready low after cmd");
    rd(8'h05, 8'h01, "R5 ready within two");
    rd(8'h04, rbyte(0), "R8 rewound by cmd");
    rd(8'h30, 8'h00, "R5 act restored");
    rd(8'h31, 8'h00, "R5 rchk restored");
    rd(8'h42, 8'h01, "R5 memctl restored");
    rd(8'h70, 8'h00, "R5 irqn restored");
    rd(8'h71, 8'h02, "R5 irqt restored");
    rd(8'h06, 8'h05, "R5 csn kept");
    chk({7'b0, dev_active_o}, 8'h00, "R5 dev_active_o");
    chk({7'b0, cfg_state_o}, 8'h01, "R5 still configured");
    // R3 csn clear
    wr(8'h02, 8'h04);
    chk(csn_o, 8'h00, "R3 csn cleared");
    chk({7'b0, cfg_state_o}, 8'h01, "R3 still configured");
    // R4 back to wait-for-key
    wr(8'h06, 8'h09);
    wr(8'h02, 8'h02);
    chk({7'b0, cfg_state_o}, 8'h00, "R4 wait-key");
    rd(8'h06, 8'h00, "R4 read blocked");
    chk(csn_o, 8'h09, "R4 csn untouched");
    idle(); idle();
    done = 1'b1;
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule